// File: doc/BRIEF.md
# Dual-Mode Grayscale PWM Engine

This block turns one 16-bit brightness value per channel into an on/off enable for each of 48 channels. All timing is counted in edges of the grayscale clock. A display period lasts 2^16 clocks, and a 16-bit slot counter marks the position inside it. In conventional mode a channel lights for one contiguous run of clocks at the start of the period. The run length equals the channel's value. In spread mode the same total on-time is split across 128 segments of 512 clocks each. Every segment receives a base run, and the leftover clocks are handed out one per segment in bit-reversed segment order. This lowers the energy in the low end of the spectrum on static drives.

A write event loads a new set of values. It also starts a display period if none is running. With timing reset enabled, the write also restarts the counter and blanks the outputs. With repeat enabled, periods follow one another without a break; without it, one period runs and the outputs then stay dark. With refresh enabled, the written values are held back and take effect at the next period end. A one-clock pulse marks each period end. The write port has no back-pressure: every cycle with the write strobe high is taken, and the newest write wins. The mode bits are plain levels, read on every clock.

Top module: `gs_pwm_engine`

## Requirements
- R1: After reset all enables are 0, the counter reads 0 and the period pulse is 0. The counter stays at 0 until the first write.
- R2: While a period runs, the counter rises by one on every clock edge and wraps from 2^CNT_W-1 to 0.
- R3: Conventional mode (spread_en=0). The enable produced at the k-th edge of a period (k=1..2^CNT_W) is 1 exactly when k-1 is less than the channel value. The on-time is therefore a single run of `value` clocks that starts at the first edge.
- R4: Spread mode (spread_en=1). The slot index p=k-1 splits into segment s=p[CNT_W-1:CNT_W-SEG_W] and offset o=p[CNT_W-SEG_W-1:0]. The channel is on when o < value[CNT_W-1:SEG_W] + (rev(s) < value[SEG_W-1:0]), where rev is the SEG_W-bit bit reversal. This gives one extra clock to segments in the order 0, 2^(SEG_W-1), 2^(SEG_W-2), and so on.
- R5: A channel whose value is 0 is never turned on, in either mode.
- R6: A write with tmg_rst_en=1 clears the counter to 0 and drives every enable to 0 in the cycle after that edge. PWM restarts at slot 0 on the next edge. A write with tmg_rst_en=0 leaves the counter running.
- R7: With repeat_en=1 the next period starts right after the wrap. With repeat_en=0 the enables stay 0 and the counter holds at 0 after the wrap, until the next write.
- R8: A write with refresh_en=0 takes effect from the slot that follows the write edge. A write with refresh_en=1 leaves the running values alone until the edge where the counter leaves its maximum; the new values govern the next period from slot 0.
- R9: period_upd is 1 for exactly one cycle, in the cycle after the edge at which a running counter wraps, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gs_clk | input | 1 | Grayscale clock; every register uses its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Grayscale write event, one sample per clock |
| wr_data | input | CHANNELS*CNT_W | Channel values; channel c occupies bits [c*CNT_W +: CNT_W] |
| repeat_en | input | 1 | 1 = periods repeat without a break |
| tmg_rst_en | input | 1 | 1 = a write restarts the counter and blanks the outputs |
| refresh_en | input | 1 | 1 = a write is deferred to the period end |
| spread_en | input | 1 | 0 = conventional mode, 1 = spread mode |
| chan_en | output | CHANNELS | Registered on/off enable per channel |
| period_upd | output | 1 | One-cycle pulse after a period ends |
| gs_count | output | CNT_W | Current slot counter |

## Verification
A wrong counter step or a wrong segment decode shows up within one clock as an enable that differs from its slot. The bench compares every slot of every period across all 256 values of an 8-bit configuration, in both modes, so a single misplaced clock is caught at once. A deferred write that lands early, or a pending flag that never clears, changes the enable pattern at the first slot of the next period. A period controller that fails to stop or to restart shows on gs_count and chan_en within one clock of the wrap.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
  typedef enum logic {
    GS_IDLE = 1'b0,
    GS_RUN  = 1'b1
  } gs_run_e;
endpackage

// File: rtl/gs_chan_pwm.sv
module gs_chan_pwm #(
  parameter int CNT_W = 16,
  parameter int SEG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] slot,
  input  logic [CNT_W-1:0] level,
  input  logic             spread,
  input  logic             live,
  output logic             en_q
);
  localparam int OFS_W = CNT_W - SEG_W;

  logic [SEG_W-1:0] seg, seg_rev, frac;
  logic [OFS_W-1:0] ofs, base;
  logic             extra, spread_on, conv_on;

  assign seg  = slot[CNT_W-1:OFS_W];
  assign ofs  = slot[OFS_W-1:0];
  assign base = level[CNT_W-1:SEG_W];
  assign frac = level[SEG_W-1:0];

  for (genvar i = 0; i < SEG_W; i++) begin : g_rev
    assign seg_rev[i] = seg[SEG_W-1-i];
  end

  assign extra     = seg_rev < frac;
  assign spread_on = {1'b0, ofs} < ({1'b0, base} + {{OFS_W{1'b0}}, extra});
  assign conv_on   = slot < level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= live && (spread ? spread_on : conv_on);
  end

  assert_zero_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> !en_q);

  assert_first_edge_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !spread && slot == '0 && level != '0) |=> en_q);
endmodule

// File: rtl/gs_data_latch.sv
module gs_data_latch #(
  parameter int WORD_W = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              refresh,
  input  logic              period_end,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] active
);
  logic [WORD_W-1:0] pend;
  logic              pend_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= '0;
      pend      <= '0;
      pend_full <= 1'b0;
    end else begin
      if (period_end && pend_full) begin
        active    <= pend;
        pend_full <= 1'b0;
      end
      if (wr) begin
        if (refresh) begin
          pend      <= wr_word;
          pend_full <= 1'b1;
        end else begin
          active    <= wr_word;
          pend_full <= 1'b0;
        end
      end
    end
  end

  assert_deferred_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && refresh && !period_end) |=> $stable(active));
endmodule

// File: rtl/gs_period_ctrl.sv
module gs_period_ctrl
  import gs_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             tmg_rst,
  input  logic             repeat_en,
  output logic [CNT_W-1:0] cnt,
  output logic             live,
  output logic             period_end,
  output logic             upd_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  gs_run_e state;
  logic    restart;

  assign restart    = wr && tmg_rst;
  assign live       = (state == GS_RUN) && !restart;
  assign period_end = (state == GS_RUN) && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      state <= GS_IDLE;
      upd_q <= 1'b0;
    end else begin
      upd_q <= period_end;
      if (restart) begin
        cnt   <= '0;
        state <= GS_RUN;
      end else if (state == GS_RUN) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_MAX && !repeat_en) state <= GS_IDLE;
      end else if (wr) begin
        state <= GS_RUN;
      end
    end
  end

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_RUN && !restart) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_IDLE && !wr) |=> $stable(cnt));

  assert_restart_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine #(
  parameter int CHANNELS = 48,
  parameter int CNT_W    = 16,
  parameter int SEG_W    = 7
) (
  input  logic                      gs_clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [CHANNELS*CNT_W-1:0] wr_data,
  input  logic                      repeat_en,
  input  logic                      tmg_rst_en,
  input  logic                      refresh_en,
  input  logic                      spread_en,
  output logic [CHANNELS-1:0]       chan_en,
  output logic                      period_upd,
  output logic [CNT_W-1:0]          gs_count
);
  localparam int WORD_W = CHANNELS * CNT_W;

  logic [WORD_W-1:0] active;
  logic              live, period_end;

  gs_period_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (gs_clk),
    .rst_n      (rst_n),
    .wr         (wr_valid),
    .tmg_rst    (tmg_rst_en),
    .repeat_en  (repeat_en),
    .cnt        (gs_count),
    .live       (live),
    .period_end (period_end),
    .upd_q      (period_upd)
  );

  gs_data_latch #(.WORD_W(WORD_W)) u_latch (
    .clk        (gs_clk),
    .rst_n      (rst_n),
    .wr         (wr_valid),
    .refresh    (refresh_en),
    .period_end (period_end),
    .wr_word    (wr_data),
    .active     (active)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    gs_chan_pwm #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_chan (
      .clk    (gs_clk),
      .rst_n  (rst_n),
      .slot   (gs_count),
      .level  (active[c*CNT_W +: CNT_W]),
      .spread (spread_en),
      .live   (live),
      .en_q   (chan_en[c])
    );
  end

  assert_force_off_R6: assert property (@(posedge gs_clk) disable iff (!rst_n)
    (wr_valid && tmg_rst_en) |=> chan_en == '0);
endmodule

// File: tb/gs_pwm_engine_tb.sv
module gs_pwm_engine_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int CW    = 8;
  localparam int SW    = 3;
  localparam int OW    = CW - SW;
  localparam int PER   = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0, wr = 1'b0, rpt = 1'b0, tmg = 1'b0, rfr = 1'b0, spr = 1'b0;
  logic [NCH*CW-1:0] data = '0;
  logic [NCH-1:0]    en;
  logic              upd;
  logic [CW-1:0]     gcnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gs_pwm_engine #(.CHANNELS(NCH), .CNT_W(CW), .SEG_W(SW)) u_dut (
    .gs_clk(clk), .rst_n(rst_n), .wr_valid(wr), .wr_data(data),
    .repeat_en(rpt), .tmg_rst_en(tmg), .refresh_en(rfr), .spread_en(spr),
    .chan_en(en), .period_upd(upd), .gs_count(gcnt)
  );

  function automatic int rev_seg(int s);
    int r = 0;
    for (int i = 0; i < SW; i++) if (((s >> i) & 1) != 0) r |= 1 << (SW - 1 - i);
    return r;
  endfunction

  function automatic bit exp_on(int slot, int v, bit sp);
    int seg, ofs, base, low;
    if (!sp) return slot < v;
    seg  = slot >> OW;
    ofs  = slot % (1 << OW);
    base = v >> SW;
    low  = v % (1 << SW);
    return ofs < base + ((rev_seg(seg) < low) ? 1 : 0);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Checks slots k0..k1 of the current period; slot k-1 follows the k-th edge.
  task automatic expect_span(input logic [NCH*CW-1:0] vals, input bit sp,
                             input int k0, input int k1, input string req);
    int bad [NCH];
    int first_act [NCH];
    int cnt_bad = 0, upd_bad = 0;
    for (int c = 0; c < NCH; c++) begin bad[c] = 0; first_act[c] = 0; end
    for (int k = k0; k <= k1; k++) begin
      cyc();
      for (int c = 0; c < NCH; c++) begin
        if (en[c] !== exp_on(k - 1, int'(vals[c*CW +: CW]), sp)) begin
          if (bad[c] == 0) first_act[c] = k - 1;
          bad[c]++;
        end
      end
      if (int'(gcnt) != (k % PER)) cnt_bad++;
      if (upd !== (k == PER)) upd_bad++;
    end
    for (int c = 0; c < NCH; c++)
      chk(bad[c] == 0, (vals[c*CW +: CW] == '0) ? "R5" : req, bad[c], 0);
    chk(cnt_bad == 0, "R2", cnt_bad, 0);
    chk(upd_bad == 0, "R9", upd_bad, 0);
  endtask

  task automatic start_period(input logic [NCH*CW-1:0] vals);
    data = vals; wr = 1'b1; tmg = 1'b1;
    cyc();
    wr = 1'b0; tmg = 1'b0;
    chk(en == '0, "R6", int'(en), 0);
    chk(gcnt == '0, "R6", int'(gcnt), 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    logic [NCH*CW-1:0] vals, va, vb, vc, vd;
    // R1: reset state held with no write
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (10) cyc();
    chk(en == '0, "R1", int'(en), 0);
    chk(gcnt == '0, "R1", int'(gcnt), 0);
    chk(upd == 1'b0, "R1", int'(upd), 0);

    // Full sweep of all values in both modes, one period each (R3, R4, R5)
    for (int sp = 0; sp < 2; sp++) begin
      spr = sp[0];
      for (int b = 0; b < 64; b++) begin
        for (int c = 0; c < NCH; c++) vals[c*CW +: CW] = CW'(b + 64 * c);
        start_period(vals);
        expect_span(vals, sp[0], 1, PER, sp[0] ? "R4" : "R3");
      end
    end

    // R7: single period then dark and counter held
    repeat (10) cyc();
    chk(en == '0, "R7", int'(en), 0);
    chk(gcnt == '0, "R7", int'(gcnt), 0);

    // Repeat with deferred refresh (R8) and back-to-back periods (R7)
    spr = 1'b0; rpt = 1'b1;
    va = {8'd200, 8'd3, 8'd128, 8'd1};
    vb = {8'd7, 8'd255, 8'd60, 8'd0};
    vc = {8'd100, 8'd52, 8'd51, 8'd90};
    vd = {8'd77, 8'd200, 8'd9, 8'd130};
    start_period(va);
    expect_span(va, 1'b0, 1, 100, "R3");
    data = vb; wr = 1'b1; rfr = 1'b1;
    expect_span(va, 1'b0, 101, 101, "R8");
    wr = 1'b0; rfr = 1'b0;
    expect_span(va, 1'b0, 102, PER, "R8");
    expect_span(vb, 1'b0, 1, PER, "R8");
    // Immediate write without timing reset: counter keeps running (R6, R8)
    expect_span(vb, 1'b0, 1, 50, "R7");
    data = vc; wr = 1'b1;
    expect_span(vb, 1'b0, 51, 51, "R8");
    wr = 1'b0;
    expect_span(vc, 1'b0, 52, PER, "R8");
    // Mid-period timing reset into spread mode, last period (R6, R4, R7)
    expect_span(vc, 1'b0, 1, 20, "R7");
    spr = 1'b1;
    start_period(vd);
    rpt = 1'b0;
    expect_span(vd, 1'b1, 1, PER, "R4");
    repeat (10) cyc();
    chk(en == '0, "R7", int'(en), 0);
    chk(gcnt == '0, "R7", int'(gcnt), 0);
    chk(upd == 1'b0, "R9", int'(upd), 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule